// File: doc/BRIEF.md
# Stack-Relative Halfword Store Unit with Immediate Prefixes

This unit watches a stream of 16-bit instruction words and executes one kind of instruction: a store of a register's low halfword to memory at an address relative to the stack pointer. The store's 6-bit offset field is normally a halfword count and is doubled before use. One or two prefix instructions placed just before the store change that. Each prefix carries a 13-bit field, and the unit combines the prefix fields with the offset field into an unscaled 19-bit or 32-bit byte displacement. The unit keeps the pending prefix fields from one instruction to the next.

Instructions arrive over a valid/ready handshake. A word is taken on a clock edge where `ins_valid` and `ins_ready` are both high. While a store is in progress, `ins_ready` stays low, so the next word is held back upstream.

In the cycle after a store is taken, the unit reads the source register through a register-file read port and raises `busy`. In the following cycle it presents the write on a second valid/ready handshake. The memory side holds off completion by keeping `wr_ready` low, and the write request stays unchanged until it is accepted.

If an extended displacement is odd, the unit does not issue the write. It pulses `misalign` for one cycle instead.

Top module: `sphs_store_unit`

## Requirements
- R1: A word is a store when bits 15:10 are 010110. Its offset field is bits 9:4 and its source register index is bits 3:0. A word is a prefix when bits 15:13 are 110, and its 13-bit field is bits 12:0. Every other word is consumed with no memory effect.
- R2: When no prefix is pending, the write address is the stack pointer plus twice the offset field.
- R3: When one prefix is pending, the displacement is {prefix field, offset field}. This 19-bit value is zero-extended and added to the stack pointer modulo 2^32, with no scaling.
- R4: When two prefixes are pending, the displacement is {older field, newer field, offset field}, a 32-bit value. It is added to the stack pointer modulo 2^32.
- R5: When a third prefix arrives in a row, the oldest pending prefix is dropped, so only the two most recent prefixes are ever used.
- R6: Consuming any word that is not a prefix clears all pending prefixes. This applies to stores, including stores that fault, and to words that are neither stores nor prefixes.
- R7: The write data carries the low 16 bits of the source register on both halfword lanes of the 32-bit bus. The 2-bit lane select is 01 when address bit 1 is 0 and 10 when address bit 1 is 1.
- R8: In the cycle after a store is taken, `busy` is 1 and `ins_ready` is 0. In the cycle after that, either `wr_valid` or `misalign` is 1.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr`, `wr_data` and `wr_hsel` hold their values. `ins_ready` stays 0 until the write is accepted.
- R10: An extended displacement (one or two prefixes) with bit 0 set produces a one-cycle `misalign` pulse in place of the write, and no write is issued.
- R11: After reset, `ins_ready` is 1, `busy`, `wr_valid` and `misalign` are 0, and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit can take an instruction word |
| ins_word | input | 16 | Instruction word |
| sp_val | input | 32 | Stack pointer value, sampled when a store is taken |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data for `rf_raddr` |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data, halfword copied on both lanes |
| wr_hsel | output | 2 | Halfword lane select |
| busy | output | 1 | Register read cycle of a store |
| misalign | output | 1 | Odd extended displacement; write suppressed |

## Verification
Errors in the prefix history can only be seen through the write address of the next store. Because of this, each prefix depth and each kind of history reset is followed by a store, and the address of that store is compared. The comparison happens two cycles after the store is taken.

A fault in the sequencing state shows up in a different way. It appears as a missing or early `busy`, as a write or `misalign` that does not arrive on the second cycle, or as a request that changes while it is stalled.

A scoreboard queues each expected write or fault in issue order. This lets a dropped, extra or reordered result show up at the next output event.

// File: rtl/sphs_pkg.sv
package sphs_pkg;
  localparam int INSN_W = 16;
  localparam logic [5:0] OPC_STORE  = 6'b010110;
  localparam logic [2:0] OPC_PREFIX = 3'b110;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WRITE, ST_FAULT} st_e;

  function automatic logic is_store(input logic [INSN_W-1:0] w);
    return w[15:10] == OPC_STORE;
  endfunction

  function automatic logic is_prefix(input logic [INSN_W-1:0] w);
    return w[15:13] == OPC_PREFIX;
  endfunction
endpackage

// File: rtl/sphs_prefix_track.sv
module sphs_prefix_track #(
  parameter int PFW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_i,
  input  logic           pfx_i,
  input  logic [PFW-1:0] field_i,
  output logic [1:0]     cnt_o,
  output logic [PFW-1:0] hi_o,
  output logic [PFW-1:0] lo_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= 2'd0;
      hi_o  <= '0;
      lo_o  <= '0;
    end else if (take_i) begin
      if (pfx_i) begin
        hi_o  <= lo_o;
        lo_o  <= field_i;
        cnt_o <= (cnt_o == 2'd2) ? 2'd2 : cnt_o + 2'd1;
      end else begin
        cnt_o <= 2'd0;
      end
    end
  end

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o != 2'd3);
  assert_oldest_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && pfx_i && cnt_o == 2'd2) |=> (cnt_o == 2'd2 && hi_o == $past(lo_o)));
  assert_history_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !pfx_i) |=> (cnt_o == 2'd0));
endmodule

// File: rtl/sphs_addr_gen.sv
module sphs_addr_gen #(
  parameter int AW   = 32,
  parameter int IMMW = 6,
  parameter int PFW  = 13
) (
  input  logic [AW-1:0]   sp_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [1:0]      cnt_i,
  input  logic [PFW-1:0]  hi_i,
  input  logic [PFW-1:0]  lo_i,
  output logic [AW-1:0]   addr_o,
  output logic            odd_o
);
  localparam int ONE_W = PFW + IMMW;
  localparam int TWO_W = 2 * PFW + IMMW;

  logic [AW-1:0] disp;

  always_comb begin
    unique case (cnt_i)
      2'd0:    disp = AW'({imm_i, 1'b0});
      2'd1:    disp = AW'(ONE_W'({lo_i, imm_i}));
      default: disp = AW'(TWO_W'({hi_i, lo_i, imm_i}));
    endcase
    addr_o = sp_i + disp;
    odd_o  = (cnt_i != 2'd0) && imm_i[0];
  end
endmodule

// File: rtl/sphs_store_core.sv
module sphs_store_core import sphs_pkg::*; #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int HW  = 16,
  parameter int RIW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            odd_i,
  input  logic [RIW-1:0]  idx_i,
  output logic            idle_o,
  output logic [RIW-1:0]  rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [DW/HW-1:0] wr_hsel,
  output logic            busy,
  output logic            misalign
);
  localparam int LANES = DW / HW;
  localparam int LSB   = $clog2(HW / 8);
  localparam int LSEL  = (LANES > 1) ? $clog2(LANES) : 1;

  st_e           state;
  logic [AW-1:0] addr_r;
  logic          odd_r;
  logic [RIW-1:0] idx_r;
  logic [HW-1:0] data_r;
  logic          unused_rf_hi;

  assign unused_rf_hi = ^rf_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_r <= '0;
      odd_r  <= 1'b0;
      idx_r  <= '0;
      data_r <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go_i) begin
          addr_r <= addr_i;
          odd_r  <= odd_i;
          idx_r  <= idx_i;
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          data_r <= rf_rdata[HW-1:0];
          state  <= odd_r ? ST_FAULT : ST_WRITE;
        end
        ST_WRITE: if (wr_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (state == ST_IDLE);
  assign busy     = (state == ST_EXEC);
  assign wr_valid = (state == ST_WRITE);
  assign misalign = (state == ST_FAULT);
  assign rf_raddr = idx_r;
  assign wr_addr  = addr_r;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wr_data[g*HW +: HW] = data_r;
    end
    if (LANES > 1) begin : g_sel
      assign wr_hsel = LANES'(1) << addr_r[LSB +: LSEL];
    end else begin : g_one
      assign wr_hsel = 1'b1;
    end
  endgenerate

  assert_second_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (wr_valid || misalign));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_hsel)));
  assert_hsel_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($countones(wr_hsel) == 1));
  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> (!misalign && !wr_valid && idle_o));
endmodule

// File: rtl/sphs_store_unit.sv
module sphs_store_unit import sphs_pkg::*; #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int HW   = 16,
  parameter int NREG = 16,
  parameter int PFW  = 13,
  parameter int IMMW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid,
  output logic                   ins_ready,
  input  logic [INSN_W-1:0]      ins_word,
  input  logic [AW-1:0]          sp_val,
  output logic [$clog2(NREG)-1:0] rf_raddr,
  input  logic [DW-1:0]          rf_rdata,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [AW-1:0]          wr_addr,
  output logic [DW-1:0]          wr_data,
  output logic [DW/HW-1:0]       wr_hsel,
  output logic                   busy,
  output logic                   misalign
);
  localparam int RIW = $clog2(NREG);

  logic           take, pfx, st, idle;
  logic [1:0]     cnt;
  logic [PFW-1:0] hi, lo;
  logic [AW-1:0]  ea;
  logic           odd;

  assign take      = ins_valid && ins_ready;
  assign pfx       = is_prefix(ins_word);
  assign st        = is_store(ins_word);
  assign ins_ready = idle;

  sphs_prefix_track #(.PFW(PFW)) u_pfx (
    .clk(clk), .rst_n(rst_n), .take_i(take), .pfx_i(pfx),
    .field_i(ins_word[PFW-1:0]), .cnt_o(cnt), .hi_o(hi), .lo_o(lo)
  );

  sphs_addr_gen #(.AW(AW), .IMMW(IMMW), .PFW(PFW)) u_ea (
    .sp_i(sp_val), .imm_i(ins_word[RIW +: IMMW]), .cnt_i(cnt),
    .hi_i(hi), .lo_i(lo), .addr_o(ea), .odd_o(odd)
  );

  sphs_store_core #(.AW(AW), .DW(DW), .HW(HW), .RIW(RIW)) u_core (
    .clk(clk), .rst_n(rst_n), .go_i(take && st), .addr_i(ea), .odd_i(odd),
    .idx_i(ins_word[RIW-1:0]), .idle_o(idle), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_hsel(wr_hsel),
    .busy(busy), .misalign(misalign)
  );

  assert_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st) |=> (busy && !ins_ready));
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !ins_ready);
endmodule

// File: tb/sphs_store_unit_test.sv
module sphs_store_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [15:0] ins_word = '0;
  logic [31:0] sp_val = '0;
  logic [3:0] rf_raddr;
  logic [31:0] rf_rdata;
  logic wr_valid, wr_ready, busy, misalign;
  logic [31:0] wr_addr, wr_data;
  logic [1:0] wr_hsel;

  always #2 clk = ~clk;

  sphs_store_unit uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .sp_val(sp_val), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_hsel(wr_hsel), .busy(busy), .misalign(misalign)
  );

  function automatic logic [31:0] reg_val(input logic [3:0] i);
    return {16'hC0DE, 16'h0100 + 16'(i) * 16'h1111};
  endfunction
  assign rf_rdata = reg_val(rf_raddr);

  typedef struct packed {logic mis; logic [31:0] a; logic [31:0] d; logic [1:0] h;} exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic [31:0] last_addr = '0;
  int m_cnt = 0;
  logic [12:0] m_hi = '0, m_lo = '0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_store(input logic [5:0] imm, input logic [3:0] rs);
    return {6'b010110, imm, rs};
  endfunction
  function automatic logic [15:0] mk_pfx(input logic [12:0] f);
    return {3'b110, f};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ((wr_valid && wr_ready) || misalign)) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected output event", {misalign, wr_addr}, 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.mis) begin
          check(misalign && !wr_valid, "R10 misaligned store suppressed", {wr_valid, misalign}, 64'h1);
        end else begin
          check(wr_valid && !misalign && wr_addr == e.a, "R2/R3/R4 write address", wr_addr, e.a);
          check(wr_data == e.d && wr_hsel == e.h, "R7 data and lane select", {wr_hsel, wr_data}, {e.h, e.d});
          last_addr = wr_addr;
        end
      end
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_word = w;
    ins_valid = 1'b1;
    if (w[15:13] == 3'b110) begin
      m_hi = m_lo; m_lo = w[12:0];
      m_cnt = (m_cnt == 2) ? 2 : m_cnt + 1;
    end else if (w[15:10] == 6'b010110) begin
      exp_t e;
      logic [31:0] disp;
      if (m_cnt == 0) disp = {25'd0, w[9:4], 1'b0};
      else if (m_cnt == 1) disp = {13'd0, m_lo, w[9:4]};
      else disp = {m_hi, m_lo, w[9:4]};
      e.mis = (m_cnt != 0) && w[4];
      e.a = sp_val + disp;
      e.d = {2{reg_val(w[3:0])[15:0]}};
      e.h = e.a[1] ? 2'b10 : 2'b01;
      q.push_back(e);
      m_cnt = 0;
    end else begin
      m_cnt = 0;
    end
    @(posedge clk);
    #1 ins_valid = 1'b0;
    if (w[15:10] == 6'b010110) begin
      @(negedge clk);
      check(busy && !ins_ready, "R8 busy in first cycle", {busy, ins_ready}, 64'h2);
      @(negedge clk);
      check(wr_valid || misalign, "R8 result in second cycle", {wr_valid, misalign}, 64'h2);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (!ins_ready || q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(ins_ready == 1'b1, "R11 ready after reset", ins_ready, 1);
    check(!busy && !wr_valid && !misalign, "R11 outputs idle", {busy, wr_valid, misalign}, 0);

    // R2 no prefix; R11 no pending prefix after reset; R1 decode
    sp_val = 32'h0000_1000;
    send(mk_store(6'h03, 4'd5));
    drain();
    check(last_addr == 32'h0000_1006, "R2 scaled offset", last_addr, 32'h1006);

    // R3 one prefix (example 0x1 / 0x2 -> +0x42)
    sp_val = 32'h0000_2000;
    send(mk_pfx(13'h0001));
    send(mk_store(6'h02, 4'd0));
    drain();
    check(last_addr == 32'h0000_2042, "R3 one-prefix displacement", last_addr, 32'h2042);

    // R4 two prefixes
    sp_val = 32'h1000_0000;
    send(mk_pfx(13'h1555));
    send(mk_pfx(13'h0AAA));
    send(mk_store(6'h10, 4'd7));
    drain();

    // R5 third prefix drops oldest
    send(mk_pfx(13'h1FFF));
    send(mk_pfx(13'h0002));
    send(mk_pfx(13'h0003));
    send(mk_store(6'h04, 4'd9));
    drain();
    check(last_addr == 32'h1000_0000 + 32'h0010_00C4, "R5 oldest prefix dropped", last_addr, 32'h100100C4);

    // R6 unrelated word clears prefix; R1 other words consumed
    sp_val = 32'h0000_4000;
    send(mk_pfx(13'h0123));
    send(16'h0000);
    send(mk_store(6'h05, 4'd3));
    drain();
    check(last_addr == 32'h0000_400A, "R6 other word clears prefix", last_addr, 32'h400A);

    // R10 misaligned, then R6 fault clears prefix, no-prefix odd offset fine
    send(mk_pfx(13'h0000));
    send(mk_store(6'h01, 4'd2));
    send(mk_store(6'h01, 4'd2));
    drain();
    check(last_addr == 32'h0000_4002, "R10 unscaled odd not misaligned", last_addr, 32'h4002);

    // R3/R4 wrap modulo 2^32
    sp_val = 32'hFFFF_FFF0;
    send(mk_pfx(13'h1FFF));
    send(mk_pfx(13'h1FFF));
    send(mk_store(6'h3E, 4'd15));
    drain();
    check(last_addr == 32'hFFFF_FFEE, "R4 wrap", last_addr, 32'hFFFFFFEE);
    sp_val = 32'hFFFF_FFFE;
    send(mk_pfx(13'h0000));
    send(mk_store(6'h04, 4'd1));
    drain();
    check(last_addr == 32'h0000_0002, "R3 wrap", last_addr, 32'h2);

    // R9 back-pressure
    sp_val = 32'h0000_8000;
    @(negedge clk);
    wr_ready = 1'b0;
    send(mk_store(6'h11, 4'd6));
    begin
      logic [31:0] a0, d0;
      logic [1:0] h0;
      a0 = wr_addr; d0 = wr_data; h0 = wr_hsel;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(wr_valid && !ins_ready && wr_addr == a0 && wr_data == d0 && wr_hsel == h0,
              "R9 held under stall", {wr_valid, ins_ready, wr_addr}, {2'b10, a0});
      end
    end
    @(posedge clk);
    #1 wr_ready = 1'b1;
    drain();
    check(last_addr == 32'h0000_8022, "R9 write completes after stall", last_addr, 32'h8022);

    repeat (3) @(negedge clk);
    check(q.size() == 0 && ins_ready, "R8 scoreboard empty", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule